// File: doc/BRIEF.md
# I2C Master Bus Event Sequencer

This block drives single bus events for an I2C master on open-drain clock and data lines. Software writes a control register in which five one-hot command bits each request one event: a Start, a Repeated Start, a Stop, the receive of one byte, or a single acknowledge pulse. Writing the transmit buffer while the block is idle sends one byte and collects the slave's acknowledge. Each event runs to completion on the bus. The hardware then clears the command bit, pulses `done` for one cycle and drops `busy`.

Commands are not queued. While an event runs, control writes and transmit-buffer writes are refused entirely. Each SCL phase lasts `PHASE_CLKS` system clocks. A data bit takes three phases: SCL low while SDA is set up, SCL high while SDA is sampled, and SCL low again before SDA may change. The acknowledge bit returned by a slave after a transmitted byte is recorded. The value the master sends in its own acknowledge pulse is programmable. A received byte lands in a receive buffer and raises a full flag.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, the control register reads 0x00, `busy`, `done` and `rxFull` are low, and neither bus line is pulled low.
- R2: Writing control bit 0 (Start) while idle pulls SDA low while SCL is high, then pulls SCL low. Bit 0 then reads back 0.
- R3: Writing control bit 1 (Repeated Start) releases SDA with SCL low, releases SCL, pulls SDA low while SCL is high, and then pulls SCL low. No Stop appears on the bus, and bit 1 clears itself.
- R4: Writing control bit 2 (Stop) pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high. Both lines end released, and bit 2 clears itself.
- R5: A transmit-buffer write while idle produces exactly 9 SCL pulses. Pulses 1 to 8 carry the byte MSB first, and during pulse 9 the master releases SDA.
- R6: Control bit 6 is read-only. After a transmitted byte it reads 0 if SDA was low during pulse 9 (acknowledged) and 1 if SDA was high (not acknowledged).
- R7: Writing control bit 4 (acknowledge) produces one SCL pulse. During that pulse SDA carries control bit 5, where 0 pulls SDA low and 1 leaves it released.
- R8: Writing control bit 3 (receive) produces 8 SCL pulses. The bits sampled on them, MSB first, appear on `rxData` and `rxFull` is set. A one-cycle `rxRead` clears `rxFull`.
- R9: While `busy` is high, control writes change nothing (bit 7 and bit 5 included) and transmit-buffer writes start nothing.
- R10: When several command bits are written at once, only the lowest-numbered one runs. A control write that carries a command takes precedence over a transmit-buffer write in the same cycle.
- R11: Control bit 7 is stored and reads back, but writing it starts no bus activity and no `done`.
- R12: `done` is a single-cycle pulse that comes once per completed event, with `busy` low and all command bits reading 0. While an event runs, at most one command bit reads 1.
- R13: SDA changes while SCL is high only during a Start, Repeated Start or Stop event.
- R14: Every SCL high phase lasts exactly `PHASE_CLKS` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write data (bit 7 spare enable, 5 ack value, 4 ack, 3 receive, 2 Stop, 1 Repeated Start, 0 Start) |
| ctrlRdData | output | 8 | Control register readback (bit 6 is the acknowledge status) |
| txWrEn | input | 1 | Transmit buffer write strobe, starts a byte transmit when idle |
| txWrData | input | 8 | Byte to transmit |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | Receive buffer holds an unread byte |
| rxRead | input | 1 | Clears rxFull |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | An event is in progress |
| done | output | 1 | One-cycle pulse when an event completes |

## Verification
The bench sends control and buffer writes while a byte is on the bus. A design that queued or half-accepted them would put an extra Stop or a second byte on the lines, or change the stored spare enable bit. It writes several command bits at once, and a command together with a transmit write in the same cycle. A wrong priority decoder would produce a Stop or transmit clock pulses instead of a lone Start. A bus monitor counts Start and Stop edges and SCL pulses and measures each high phase. An SDA change at the wrong time therefore shows up as a phantom Start or Stop, and an off-by-one bit counter shows up as 8 or 10 pulses instead of 9. The slave model answers with both acknowledge and not-acknowledge, and shifts out asymmetric receive patterns, so an inverted status bit or a reversed bit order is caught.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    EV_IDLE, EV_START, EV_RSTART, EV_STOP, EV_RX, EV_ACK, EV_TX
  } evKind_t;

  typedef enum logic [2:0] {
    SDA_REL, SDA_LOW, SDA_HOLD, SDA_DATA, SDA_ACK
  } sdaSel_t;

  typedef struct packed {
    logic    lineUpd;
    logic    sclLow;
    sdaSel_t sdaSel;
    logic    cfgWr;
    logic    loadTx;
    logic    shift;
    logic    ackSample;
    logic    rxDone;
    logic    done;
  } strobe_t;

  localparam int CMD_W   = 5;
  localparam int BYTE_W  = 8;

endpackage

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int PHASE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic              txWrEn,
  output logic              busy,
  output logic [CMD_W-1:0]  cmdBits,
  output strobe_t           strb
);
  localparam int DIV_W = $clog2(PHASE_CLKS) + 1;
  localparam int BIT_W = $clog2(BYTE_W + 1) + 1;

  evKind_t          ev, newEv;
  logic [1:0]       step;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             tick, isLast, finishing, cmdHit, isByte;

  assign busy      = (ev != EV_IDLE);
  assign tick      = (divCnt == DIV_W'(PHASE_CLKS - 1));
  assign cmdHit    = ctrlWrEn && (|ctrlWrData[CMD_W-1:0]);
  assign isByte    = (ev == EV_TX) || (ev == EV_RX) || (ev == EV_ACK);
  assign finishing = busy && tick && isLast;

  // lowest command bit wins; a command beats a buffer write
  always_comb begin
    newEv = EV_IDLE;
    if (ctrlWrEn && ctrlWrData[0])      newEv = EV_START;
    else if (ctrlWrEn && ctrlWrData[1]) newEv = EV_RSTART;
    else if (ctrlWrEn && ctrlWrData[2]) newEv = EV_STOP;
    else if (ctrlWrEn && ctrlWrData[3]) newEv = EV_RX;
    else if (ctrlWrEn && ctrlWrData[4]) newEv = EV_ACK;
    else if (txWrEn)                    newEv = EV_TX;
  end

  always_comb begin
    case (ev)
      EV_START:  isLast = (step == 2'd2);
      EV_RSTART: isLast = (step == 2'd3);
      EV_STOP:   isLast = (step == 2'd2);
      EV_TX:     isLast = (step == 2'd2) && (bitCnt == BIT_W'(BYTE_W));
      EV_RX:     isLast = (step == 2'd2) && (bitCnt == BIT_W'(BYTE_W - 1));
      EV_ACK:    isLast = (step == 2'd2) && (bitCnt == '0);
      default:   isLast = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ev     <= EV_IDLE;
      step   <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (!busy) begin
      ev     <= newEv;
      step   <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
      if (isLast) begin
        ev <= EV_IDLE;
      end else if (isByte && step == 2'd2) begin
        step   <= '0;
        bitCnt <= bitCnt + 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.sdaSel    = SDA_HOLD;
    strb.lineUpd   = busy;
    strb.cfgWr     = ctrlWrEn && !busy;
    strb.loadTx    = txWrEn && !busy && !cmdHit;
    strb.done      = finishing;
    strb.rxDone    = finishing && (ev == EV_RX);
    strb.shift     = tick && (step == 2'd1) && ((ev == EV_TX) || (ev == EV_RX))
                     && (bitCnt < BIT_W'(BYTE_W));
    strb.ackSample = tick && (step == 2'd1) && (ev == EV_TX) && (bitCnt == BIT_W'(BYTE_W));
    case (ev)
      EV_START: begin
        strb.sclLow = (step == 2'd2);
        strb.sdaSel = (step == 2'd0) ? SDA_REL : SDA_LOW;
      end
      EV_RSTART: begin
        strb.sclLow = (step == 2'd0) || (step == 2'd3);
        strb.sdaSel = (step < 2'd2) ? SDA_REL : SDA_LOW;
      end
      EV_STOP: begin
        strb.sclLow = (step == 2'd0);
        strb.sdaSel = (step == 2'd2) ? SDA_REL : SDA_LOW;
      end
      EV_TX, EV_RX, EV_ACK: begin
        strb.sclLow = (step != 2'd1);
        if (step == 2'd0) begin
          if (ev == EV_ACK)                             strb.sdaSel = SDA_ACK;
          else if (ev == EV_TX && bitCnt < BIT_W'(BYTE_W)) strb.sdaSel = SDA_DATA;
          else                                          strb.sdaSel = SDA_REL;
        end
      end
      default: strb.sclLow = 1'b0;
    endcase
  end

  assign cmdBits = {ev == EV_ACK, ev == EV_RX, ev == EV_STOP, ev == EV_RSTART, ev == EV_START};

endmodule

// File: rtl/i2cseq_datapath.sv
module i2cseq_datapath
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        ctrlWrData,
  input  logic [BYTE_W-1:0] txWrData,
  input  logic              sdaIn,
  input  logic              rxRead,
  output logic              sclLow,
  output logic              sdaLow,
  output logic              spareEn,
  output logic              ackVal,
  output logic              ackStat,
  output logic [BYTE_W-1:0] rxBuf,
  output logic              rxFull,
  output logic              donePulse
);
  logic [BYTE_W-1:0] shiftReg;
  logic              sdaTarget;

  always_comb begin
    case (strb.sdaSel)
      SDA_REL:  sdaTarget = 1'b0;
      SDA_LOW:  sdaTarget = 1'b1;
      SDA_DATA: sdaTarget = ~shiftReg[BYTE_W-1];
      SDA_ACK:  sdaTarget = ~ackVal;
      default:  sdaTarget = sdaLow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclLow    <= 1'b0;
      sdaLow    <= 1'b0;
      spareEn   <= 1'b0;
      ackVal    <= 1'b0;
      ackStat   <= 1'b0;
      shiftReg  <= '0;
      rxBuf     <= '0;
      rxFull    <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= strb.done;
      if (strb.lineUpd) begin
        sclLow <= strb.sclLow;
        sdaLow <= sdaTarget;
      end
      if (strb.cfgWr) begin
        spareEn <= ctrlWrData[7];
        ackVal  <= ctrlWrData[5];
      end
      if (strb.loadTx)         shiftReg <= txWrData;
      else if (strb.shift)     shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      if (strb.ackSample)      ackStat  <= sdaIn;
      if (strb.rxDone) begin
        rxBuf  <= shiftReg;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int PHASE_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  output logic [7:0] ctrlRdData,
  input  logic       txWrEn,
  input  logic [7:0] txWrData,
  output logic [7:0] rxData,
  output logic       rxFull,
  input  logic       rxRead,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       busy,
  output logic       done
);
  strobe_t          strb;
  logic [CMD_W-1:0] cmdBits;
  logic             spareEn, ackVal, ackStat;

  i2cseq_ctrl #(.PHASE_CLKS(PHASE_CLKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .txWrEn     (txWrEn),
    .busy       (busy),
    .cmdBits    (cmdBits),
    .strb       (strb)
  );

  i2cseq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ctrlWrData (ctrlWrData),
    .txWrData   (txWrData),
    .sdaIn      (sdaIn),
    .rxRead     (rxRead),
    .sclLow     (sclDriveLow),
    .sdaLow     (sdaDriveLow),
    .spareEn    (spareEn),
    .ackVal     (ackVal),
    .ackStat    (ackStat),
    .rxBuf      (rxData),
    .rxFull     (rxFull),
    .donePulse  (done)
  );

  assign ctrlRdData = {spareEn, ackStat, ackVal, cmdBits};

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWrEn,
  input logic [7:0] ctrlRdData,
  input logic       rxFull,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic       busy,
  input logic       done
);

  // R13
  sda_edge_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclDriveLow && !$past(sclDriveLow) && (sdaDriveLow != $past(sdaDriveLow)))
      |-> (|$past(ctrlRdData[2:0])));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && ctrlRdData[4:0] == 5'd0));

  // R12
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlRdData[4:0]));

  // R9
  busy_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWrEn) |=> ($stable(ctrlRdData[7]) && $stable(ctrlRdData[5])));

  // R8
  rxfull_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> done);

endmodule

bind i2cseq_top i2cseq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrEn    (ctrlWrEn),
  .ctrlRdData  (ctrlRdData),
  .rxFull      (rxFull),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_i2cseq_top.sv
module tb_i2cseq_top;
  localparam int PHASE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic [7:0] rxData;
  logic       rxFull;
  logic       rxRead = 1'b0;
  logic       sdaIn;
  logic       sclDriveLow, sdaDriveLow, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bus and slave model
  logic       slaveLow;
  int         slaveMode = 0;
  bit         slaveAck = 1'b0;
  logic [7:0] slavePat = '0;
  int         fallBase = 0;
  logic       sclLine, sdaLine, prevScl = 1'b1, prevSda = 1'b1;
  int         startCnt = 0, stopCnt = 0, capCnt = 0, fallCnt = 0, doneCnt = 0;
  int         highLen = 0, lastHigh = 0;
  logic [15:0] capBits = '0;

  always #5 clk = ~clk;

  i2cseq_top #(.PHASE_CLKS(PHASE)) dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxData(rxData), .rxFull(rxFull), .rxRead(rxRead), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done)
  );

  always_comb begin
    int rel;
    rel = fallCnt - fallBase;
    slaveLow = 1'b0;
    if (slaveMode == 1) slaveLow = slaveAck && (rel == 8);
    else if (slaveMode == 2 && rel >= 0 && rel < 8) slaveLow = !slavePat[7 - rel];
  end

  assign sclLine = !sclDriveLow;
  assign sdaLine = !(sdaDriveLow || slaveLow);
  assign sdaIn   = sdaLine;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevScl && sclLine && prevSda && !sdaLine) startCnt <= startCnt + 1;
      if (prevScl && sclLine && !prevSda && sdaLine) stopCnt <= stopCnt + 1;
      if (!prevScl && sclLine) begin
        capBits <= {capBits[14:0], sdaLine};
        capCnt  <= capCnt + 1;
        highLen <= 1;
      end else if (prevScl && sclLine) begin
        highLen <= highLen + 1;
      end
      if (prevScl && !sclLine) begin
        fallCnt  <= fallCnt + 1;
        lastHigh <= highLen;
      end
      if (done) doneCnt <= doneCnt + 1;
    end
    prevScl <= sclLine;
    prevSda <= sdaLine;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] d);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk);
    txWrEn = 1'b1; txWrData = d;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ctrl readback", ctrlRdData, 8'h00);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rxFull", rxFull, 0);
    chk("R1", "scl pulled", sclDriveLow, 0);
    chk("R1", "sda pulled", sdaDriveLow, 0);
  endtask

  task automatic testStart();
    int s0 = startCnt, p0 = stopCnt, d0 = doneCnt;
    writeCtrl(8'h01);
    chk("R12", "busy while start runs", busy, 1);
    chk("R12", "start bit while running", ctrlRdData[4:0], 5'h01);
    waitDone();
    chk("R2", "start edges", startCnt - s0, 1);
    chk("R2", "stop edges", stopCnt - p0, 0);
    chk("R2", "scl held low after start", sclDriveLow, 1);
    chk("R2", "start bit cleared", ctrlRdData[0], 0);
    chk("R12", "done pulses", doneCnt - d0, 1);
  endtask

  task automatic testTx(input logic [7:0] b, input bit ack);
    int c0 = capCnt, s0 = startCnt, p0 = stopCnt;
    slaveMode = 1; slaveAck = ack; fallBase = fallCnt;
    writeTx(b);
    waitDone();
    chk("R5", "tx scl pulses", capCnt - c0, 9);
    chk("R5", "tx byte on bus", capBits[8:1], b);
    chk("R6", "ack status", ctrlRdData[6], !ack);
    chk("R13", "no start during byte", startCnt - s0, 0);
    chk("R13", "no stop during byte", stopCnt - p0, 0);
    chk("R14", "scl high length", lastHigh, PHASE);
    slaveMode = 0;
  endtask

  task automatic testBusyRefuse();
    int c0 = capCnt, p0 = stopCnt;
    slaveMode = 1; slaveAck = 1'b1; fallBase = fallCnt;
    writeTx(8'h5A);
    writeCtrl(8'hA4);
    writeTx(8'hFF);
    waitDone();
    chk("R9", "byte kept", capBits[8:1], 8'h5A);
    chk("R9", "no stop from busy write", stopCnt - p0, 0);
    chk("R9", "spare bit untouched", ctrlRdData[7], 0);
    chk("R9", "ack value untouched", ctrlRdData[5], 0);
    repeat (40) @(negedge clk);
    chk("R9", "no second byte", capCnt - c0, 9);
    chk("R9", "idle after refusal", busy, 0);
    slaveMode = 0;
  endtask

  task automatic testRstart();
    int s0 = startCnt, p0 = stopCnt;
    writeCtrl(8'h02);
    chk("R3", "rstart bit while running", ctrlRdData[4:0], 5'h02);
    waitDone();
    chk("R3", "rstart edge", startCnt - s0, 1);
    chk("R3", "no stop", stopCnt - p0, 0);
    chk("R3", "scl low after", sclDriveLow, 1);
    chk("R3", "rstart bit cleared", ctrlRdData[1], 0);
  endtask

  task automatic testRx(input logic [7:0] pat);
    int c0 = capCnt;
    slavePat = pat; fallBase = fallCnt; slaveMode = 2;
    writeCtrl(8'h08);
    waitDone();
    chk("R8", "rx scl pulses", capCnt - c0, 8);
    chk("R8", "rx byte", rxData, pat);
    chk("R8", "rx full set", rxFull, 1);
    chk("R8", "rx bit cleared", ctrlRdData[3], 0);
    slaveMode = 0;
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
    chk("R8", "rx full cleared", rxFull, 0);
  endtask

  task automatic testAck(input bit v);
    int c0 = capCnt;
    writeCtrl(8'h10 | (v ? 8'h20 : 8'h00));
    waitDone();
    chk("R7", "ack pulses", capCnt - c0, 1);
    chk("R7", "ack level", capBits[0], v);
    chk("R7", "ack bit cleared", ctrlRdData[4], 0);
    chk("R7", "ack value stored", ctrlRdData[5], v);
  endtask

  task automatic testStop();
    int s0 = startCnt, p0 = stopCnt;
    writeCtrl(8'h04);
    waitDone();
    chk("R4", "stop edge", stopCnt - p0, 1);
    chk("R4", "no start", startCnt - s0, 0);
    chk("R4", "scl released", sclDriveLow, 0);
    chk("R4", "sda released", sdaDriveLow, 0);
    chk("R4", "stop bit cleared", ctrlRdData[2], 0);
  endtask

  task automatic testPriority();
    int s0 = startCnt, p0 = stopCnt, c0 = capCnt;
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = 8'h05; txWrEn = 1'b1; txWrData = 8'h77;
    @(negedge clk);
    ctrlWrEn = 1'b0; txWrEn = 1'b0;
    chk("R10", "only start runs", ctrlRdData[4:0], 5'h01);
    waitDone();
    chk("R10", "start edges", startCnt - s0, 1);
    chk("R10", "stop edges", stopCnt - p0, 0);
    chk("R10", "no tx pulses", capCnt - c0, 0);
  endtask

  task automatic testSpare();
    int d0 = doneCnt;
    writeCtrl(8'hC0);
    repeat (10) @(negedge clk);
    chk("R11", "spare bit stored", ctrlRdData[7], 1);
    chk("R11", "no busy", busy, 0);
    chk("R11", "no done", doneCnt - d0, 0);
    chk("R11", "lines released", {sclDriveLow, sdaDriveLow}, 0);
    chk("R6", "status bit not writable", ctrlRdData[6], 0);
  endtask

  initial begin
    testReset();
    testStart();
    testTx(8'hA5, 1'b1);
    testTx(8'h3C, 1'b0);
    testBusyRefuse();
    testRstart();
    testRx(8'hC3);
    testAck(1'b0);
    testRx(8'h96);
    testAck(1'b1);
    testStop();
    testPriority();
    testStop();
    testSpare();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule